// File: doc/BRIEF.md
# Four-Level Nested Interrupt Priority Controller

This block arbitrates six interrupt request sources for a small 8-bit processor core. The six sources are two external inputs, two timers, a serial port and a third timer. Each source gets a two-bit priority level from two separate register bits, a high bit and a low bit, which gives four levels. Among the eligible requests the controller picks the one with the highest level. Ties within a level go to a fixed polling order. The controller then raises a registered request to the core with the matching vector address.

When the core acknowledges the request, the controller marks that level as in service. Only a request of strictly higher level can then reach the core, so services nest. On each return-from-interrupt the controller retires the highest level in service, and the preempted service becomes the active one again. On acknowledge the controller also pulses a one-cycle clear strobe for the flags that hardware must clear. These are the timer 0 and timer 1 overflow flags, and an external flag only when that input is set to transition mode.

Top module: `irq_nest_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `irq_o` is 0, `vector_o` is 0, all clear strobes are 0 and no level is in service.
- R2: A source's level is `{prio_hi_i[s], prio_lo_i[s]}`, with 3 the highest. The eligible source with the highest level wins, whatever its position in the polling order.
- R3: Among eligible sources of equal level, the winner is the lowest source index. The indices are 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2.
- R4: `vector_o` is 8'h03 + 8 × (winning index), so 03, 0B, 13, 1B, 23, 2B. It is 0 whenever `irq_o` is 0.
- R5: A source is eligible only if its flag, its bit of `src_en_i` and `glob_en_i` are all 1.
- R6: A request whose level is equal to or lower than the highest level in service is held back until that level returns.
- R7: A request of strictly higher level than every level in service is raised and can be acknowledged, which nests it. After return, a held lower-level request is raised.
- R8: `ack_i` while `irq_o` is 1 marks the current winner's level in service, and `irq_o` is 0 in the next cycle. `ack_i` while `irq_o` is 0 has no effect.
- R9: In the cycle after an accepted acknowledge, a one-cycle strobe appears. For timer 0 or timer 1 it is `tmr_clr_o[0]` or `tmr_clr_o[1]`. For external 0 or external 1 it is `ext_clr_o[0]` or `ext_clr_o[1]`, but only when `ext_edge_i` for that input is 1. The serial port and timer 2 never get a strobe.
- R10: The serial request is `ser_rx_i | ser_tx_i`. The timer 2 request is `tmr2_ovf_i | tmr2_ext_i`.
- R11: `reti_i` retires only the highest level in service. With nothing in service it has no effect.
- R12: `irq_o` and `vector_o` are registered. A change on the request inputs shows on them one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_flag_i | input | 2 | External interrupt flags (bit 0 = external 0) |
| ext_edge_i | input | 2 | 1 = external input is transition-activated |
| tmr_flag_i | input | 2 | Timer 0 / timer 1 overflow flags |
| ser_rx_i | input | 1 | Serial receive flag |
| ser_tx_i | input | 1 | Serial transmit flag |
| tmr2_ovf_i | input | 1 | Timer 2 overflow flag |
| tmr2_ext_i | input | 1 | Timer 2 external flag |
| src_en_i | input | 6 | Per-source enables, indexed as in R3 |
| glob_en_i | input | 1 | Global enable |
| prio_hi_i | input | 6 | High priority bit per source |
| prio_lo_i | input | 6 | Low priority bit per source |
| ack_i | input | 1 | Core vectors to the current request |
| reti_i | input | 1 | Core returns from the current service |
| irq_o | output | 1 | Interrupt request to the core |
| vector_o | output | 8 | Vector address of the request |
| ext_clr_o | output | 2 | Clear strobes for the external flags |
| tmr_clr_o | output | 2 | Clear strobes for the timer 0/1 flags |

## Verification
The bench works through nested services across three levels. It holds a level-1 request behind a level-1 service, which an arbiter comparing with greater-or-equal would let through. It returns twice and expects the held requests to come back in level order; a controller that cleared the whole stack, or the lowest bit, would release them too early. It compares the clear strobes for an edge-mode external input, a level-mode one, a timer and the serial port, catching a strobe that ignores the mode or reaches the wrong source. It also sends an acknowledge with no request pending and a return with nothing in service, and then shows that a level-0 request is still served.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

    localparam int NUM_SRC    = 6;
    localparam int NUM_LVL    = 4;
    localparam int LVL_W      = $clog2(NUM_LVL);
    localparam int SRC_W      = $clog2(NUM_SRC);
    localparam int VEC_W      = 8;
    localparam int VEC_BASE   = 3;
    localparam int VEC_STRIDE = 8;
    localparam int NUM_EXT    = 2;

    typedef logic [LVL_W-1:0]   lvl_t;
    typedef logic [SRC_W-1:0]   src_t;
    typedef logic [NUM_LVL-1:0] lvl_mask_t;
    typedef logic [VEC_W-1:0]   vec_t;

    typedef struct packed {
        logic valid;
        lvl_t lvl;
        src_t src;
    } pick_t;

    // Source slots: external k sits at 2k, timer k at 2k+1.
    function automatic src_t ext_src(int k);
        return src_t'(2 * k);
    endfunction

    function automatic src_t tmr_src(int k);
        return src_t'(2 * k + 1);
    endfunction

    function automatic vec_t vec_of(src_t s);
        return vec_t'(VEC_BASE + VEC_STRIDE * int'(s));
    endfunction

    function automatic lvl_t top_of(lvl_mask_t m);
        lvl_t t = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (m[i]) t = lvl_t'(i);
        end
        return t;
    endfunction

endpackage

// File: rtl/irq_src_map.sv
module irq_src_map
    import irq_nest_pkg::*;
(
    input  logic [NUM_SRC-1:0]            raw_i,
    input  logic [NUM_SRC-1:0]            en_i,
    input  logic                          glob_i,
    input  logic [NUM_SRC-1:0]            hi_i,
    input  logic [NUM_SRC-1:0]            lo_i,
    input  logic                          busy_i,
    input  lvl_t                          top_i,
    output logic [NUM_SRC-1:0]            elig_o,
    output logic [NUM_SRC-1:0][LVL_W-1:0] lvl_o
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        lvl_t lvl;
        assign lvl       = {hi_i[g], lo_i[g]};
        assign lvl_o[g]  = lvl;
        assign elig_o[g] = raw_i[g] & en_i[g] & glob_i & (!busy_i || (lvl > top_i));
    end

endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_nest_pkg::*;
(
    input  logic [NUM_SRC-1:0]            elig_i,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_i,
    output pick_t                         pick_o
);

    // Scan from the last slot down; ">=" lets a lower index take a tie.
    always_comb begin
        pick_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig_i[i] && (!pick_o.valid || lvl_t'(lvl_i[i]) >= pick_o.lvl)) begin
                pick_o.valid = 1'b1;
                pick_o.lvl   = lvl_t'(lvl_i[i]);
                pick_o.src   = src_t'(i);
            end
        end
    end

endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
    import irq_nest_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic push_i,
    input  lvl_t push_lvl_i,
    input  logic pop_i,
    output logic busy_o,
    output lvl_t top_o
);

    lvl_mask_t mask_q;
    lvl_mask_t mask_d;

    assign busy_o = |mask_q;
    assign top_o  = top_of(mask_q);

    always_comb begin
        mask_d = mask_q;
        if (pop_i && busy_o) mask_d[top_o] = 1'b0;
        if (push_i)          mask_d[push_lvl_i] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= mask_d;
    end

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_nest_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EXT-1:0] ext_flag_i,
    input  logic [NUM_EXT-1:0] ext_edge_i,
    input  logic [NUM_EXT-1:0] tmr_flag_i,
    input  logic               ser_rx_i,
    input  logic               ser_tx_i,
    input  logic               tmr2_ovf_i,
    input  logic               tmr2_ext_i,
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic               glob_en_i,
    input  logic [NUM_SRC-1:0] prio_hi_i,
    input  logic [NUM_SRC-1:0] prio_lo_i,
    input  logic               ack_i,
    input  logic               reti_i,
    output logic               irq_o,
    output logic [VEC_W-1:0]   vector_o,
    output logic [NUM_EXT-1:0] ext_clr_o,
    output logic [NUM_EXT-1:0] tmr_clr_o
);

    logic [NUM_SRC-1:0]            raw;
    logic [NUM_SRC-1:0]            elig;
    logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
    logic                          busy;
    lvl_t                          top;
    pick_t                         pick;
    pick_t                         held_q;
    logic                          irq_q;
    vec_t                          vec_q;
    logic                          take;
    logic [NUM_EXT-1:0]            ext_clr_d, ext_clr_q;
    logic [NUM_EXT-1:0]            tmr_clr_d, tmr_clr_q;

    assign raw = {tmr2_ovf_i | tmr2_ext_i,
                  ser_rx_i | ser_tx_i,
                  tmr_flag_i[1], ext_flag_i[1],
                  tmr_flag_i[0], ext_flag_i[0]};

    assign take = ack_i & irq_q;

    irq_src_map u_map (
        .raw_i  (raw),
        .en_i   (src_en_i),
        .glob_i (glob_en_i),
        .hi_i   (prio_hi_i),
        .lo_i   (prio_lo_i),
        .busy_i (busy),
        .top_i  (top),
        .elig_o (elig),
        .lvl_o  (lvl)
    );

    irq_pick u_pick (
        .elig_i (elig),
        .lvl_i  (lvl),
        .pick_o (pick)
    );

    irq_level_stack u_stack (
        .clk        (clk),
        .rst        (rst),
        .push_i     (take),
        .push_lvl_i (held_q.lvl),
        .pop_i      (reti_i),
        .busy_o     (busy),
        .top_o      (top)
    );

    for (genvar k = 0; k < NUM_EXT; k++) begin : g_clr
        assign ext_clr_d[k] = take && (held_q.src == ext_src(k)) && ext_edge_i[k];
        assign tmr_clr_d[k] = take && (held_q.src == tmr_src(k));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q     <= 1'b0;
            vec_q     <= '0;
            held_q    <= '0;
            ext_clr_q <= '0;
            tmr_clr_q <= '0;
        end else begin
            irq_q     <= pick.valid && !take;
            vec_q     <= (pick.valid && !take) ? vec_of(pick.src) : '0;
            held_q    <= pick;
            ext_clr_q <= ext_clr_d;
            tmr_clr_q <= tmr_clr_d;
        end
    end

    assign irq_o     = irq_q;
    assign vector_o  = vec_q;
    assign ext_clr_o = ext_clr_q;
    assign tmr_clr_o = tmr_clr_q;

endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk (
    input logic       clk,
    input logic       rst,
    input logic       glob_en_i,
    input logic       ack_i,
    input logic       irq_o,
    input logic [7:0] vector_o,
    input logic [1:0] ext_clr_o,
    input logic [1:0] tmr_clr_o
);

    // R1: quiet outputs in the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_o && ext_clr_o == 2'b00 && tmr_clr_o == 2'b00));

    // R4: vector is one of the six slots while a request is up
    p_vec_slot_r4: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (vector_o[2:0] == 3'b011 && vector_o <= 8'h2B));

    // R4: vector is zero while idle
    p_vec_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !irq_o |-> (vector_o == 8'h00));

    // R5: no request follows a cleared global enable
    p_glob_off_r5: assert property (@(posedge clk) disable iff (rst)
        !glob_en_i |=> !irq_o);

    // R8: an accepted acknowledge drops the request
    p_ack_drops_r8: assert property (@(posedge clk) disable iff (rst)
        (ack_i && irq_o) |=> !irq_o);

    // R9: at most one clear strobe at a time
    p_clr_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ext_clr_o, tmr_clr_o}));

    // R9: a strobe only follows an accepted acknowledge
    p_clr_after_ack_r9: assert property (@(posedge clk) disable iff (rst)
        (|{ext_clr_o, tmr_clr_o}) |-> $past(ack_i && irq_o));

endmodule

bind irq_nest_ctrl irq_nest_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .glob_en_i (glob_en_i),
    .ack_i     (ack_i),
    .irq_o     (irq_o),
    .vector_o  (vector_o),
    .ext_clr_o (ext_clr_o),
    .tmr_clr_o (tmr_clr_o)
);

// File: tb/irq_nest_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_nest_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] ext_flag = '0, ext_edge = '0, tmr_flag = '0;
    logic       ser_rx = 0, ser_tx = 0, t2_ovf = 0, t2_ext = 0;
    logic [5:0] src_en = '0, prio_hi = '0, prio_lo = '0;
    logic       glob_en = 0, ack = 0, reti = 0;
    logic       irq_o;
    logic [7:0] vector_o;
    logic [1:0] ext_clr_o, tmr_clr_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_nest_ctrl dut_i (
        .clk(clk), .rst(rst),
        .ext_flag_i(ext_flag), .ext_edge_i(ext_edge), .tmr_flag_i(tmr_flag),
        .ser_rx_i(ser_rx), .ser_tx_i(ser_tx),
        .tmr2_ovf_i(t2_ovf), .tmr2_ext_i(t2_ext),
        .src_en_i(src_en), .glob_en_i(glob_en),
        .prio_hi_i(prio_hi), .prio_lo_i(prio_lo),
        .ack_i(ack), .reti_i(reti),
        .irq_o(irq_o), .vector_o(vector_o),
        .ext_clr_o(ext_clr_o), .tmr_clr_o(tmr_clr_o)
    );

    // ---------------- behavioural reference ----------------
    bit  m_stack[4];
    bit  m_irq;
    int  m_vec, m_lvl, m_src;
    int  m_ext_clr, m_tmr_clr;
    bit  r_req[6];
    int  r_lvl[6];
    int  r_top, r_win, r_wlvl;
    bit  r_take, r_popped;

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_stack[i]) m_stack[i] = 0;
            m_irq = 0; m_vec = 0; m_lvl = 0; m_src = 0;
            m_ext_clr = 0; m_tmr_clr = 0;
        end else begin
            r_req[0] = ext_flag[0]; r_req[1] = tmr_flag[0];
            r_req[2] = ext_flag[1]; r_req[3] = tmr_flag[1];
            r_req[4] = ser_rx || ser_tx;          // R10
            r_req[5] = t2_ovf || t2_ext;          // R10
            for (int i = 0; i < 6; i++) r_lvl[i] = 2 * prio_hi[i] + prio_lo[i];
            r_top = -1;
            for (int l = 0; l < 4; l++) if (m_stack[l]) r_top = l;
            r_win = -1; r_wlvl = 0;
            for (int l = 3; l >= 0; l--)
                for (int i = 0; i < 6; i++)
                    if (r_win < 0 && r_req[i] && src_en[i] && glob_en && r_lvl[i] == l && l > r_top) begin
                        r_win = i; r_wlvl = l;
                    end
            r_take = ack && m_irq;
            m_ext_clr = 0; m_tmr_clr = 0;
            if (r_take) begin
                if (m_src == 0 && ext_edge[0]) m_ext_clr = 1;
                if (m_src == 2 && ext_edge[1]) m_ext_clr = 2;
                if (m_src == 1) m_tmr_clr = 1;
                if (m_src == 3) m_tmr_clr = 2;
            end
            if (reti) begin
                r_popped = 0;
                for (int l = 3; l >= 0; l--)
                    if (!r_popped && m_stack[l]) begin m_stack[l] = 0; r_popped = 1; end
            end
            if (r_take) m_stack[m_lvl] = 1;
            m_irq = (r_win >= 0) && !r_take;
            m_vec = m_irq ? 3 + 8 * r_win : 0;
            m_lvl = r_wlvl;
            m_src = r_win;
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check(irq_o == m_irq, "R12 irq_o vs model", int'(irq_o), int'(m_irq));
            check(vector_o == m_vec[7:0], "R4 vector_o vs model", int'(vector_o), m_vec);
            check(ext_clr_o == m_ext_clr[1:0], "R9 ext_clr_o vs model", int'(ext_clr_o), m_ext_clr);
            check(tmr_clr_o == m_tmr_clr[1:0], "R9 tmr_clr_o vs model", int'(tmr_clr_o), m_tmr_clr);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_vec(string tag, int v);
        check(irq_o == 1'b1, tag, int'(irq_o), 1);
        check(vector_o == v[7:0], tag, int'(vector_o), v);
    endtask

    task automatic pulse_reti();
        reti = 1; step(1); reti = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired act=0 exp=1");
        finish_run();
    end

    initial begin
        step(3);
        check(irq_o == 0 && ext_clr_o == 0 && tmr_clr_o == 0, "R1 outputs in reset", int'(irq_o), 0);
        rst = 0;
        step(1);
        check(irq_o == 0 && vector_o == 0, "R1 outputs after reset", int'(vector_o), 0);

        // R5: enables gate eligibility
        ext_edge = 2'b01;
        ext_flag[0] = 1; glob_en = 1; src_en = 6'b000000;
        step(3);
        check(irq_o == 0, "R5 source enable off", int'(irq_o), 0);
        src_en = 6'b000001; glob_en = 0;
        step(3);
        check(irq_o == 0, "R5 global enable off", int'(irq_o), 0);
        glob_en = 1;
        step(1);
        expect_vec("R12 one-cycle latency / R4 vector 03", 8'h03);

        // R3 / R4: polling order at equal level
        ext_flag = 2'b11; tmr_flag = 2'b11; ser_tx = 1; t2_ovf = 1; src_en = 6'h3F;
        step(1); expect_vec("R3 all at level 0", 8'h03);
        ext_flag[0] = 0; step(1); expect_vec("R3 timer0 next", 8'h0B);
        tmr_flag[0] = 0; step(1); expect_vec("R3 ext1 next", 8'h13);
        ext_flag[1] = 0; step(1); expect_vec("R3 timer1 next", 8'h1B);
        tmr_flag[1] = 0; step(1); expect_vec("R3 serial next", 8'h23);
        ser_tx = 0;      step(1); expect_vec("R3 timer2 last", 8'h2B);

        // R2: level beats order
        ext_flag = 2'b11; tmr_flag = 2'b11; ser_tx = 1;
        prio_lo = 6'b001000; prio_hi = 6'b100000;
        step(1); expect_vec("R2 level 2 timer2 wins", 8'h2B);
        prio_hi = 6'b101000;
        step(1); expect_vec("R2 level 3 timer1 wins", 8'h1B);
        ext_flag = 0; tmr_flag = 0; ser_tx = 0; t2_ovf = 0; prio_hi = 0; prio_lo = 0;
        step(2);
        check(irq_o == 0, "R5 no flags no request", int'(irq_o), 0);

        // R10: merged request lines
        ser_rx = 1; step(1); expect_vec("R10 serial via receive", 8'h23);
        ser_rx = 0; t2_ext = 1; step(1); expect_vec("R10 timer2 via external flag", 8'h2B);
        t2_ext = 0; step(2);

        // Nesting: timer0 at level 1
        prio_lo[1] = 1; tmr_flag[0] = 1;
        step(1); expect_vec("R7 timer0 level 1", 8'h0B);
        ack = 1; step(1);
        check(irq_o == 0, "R8 request drops after ack", int'(irq_o), 0);
        check(tmr_clr_o == 2'b01, "R9 timer0 clear strobe", int'(tmr_clr_o), 1);
        ack = 0; tmr_flag[0] = 0;
        prio_lo[2] = 1; ext_flag[1] = 1;   // level-mode ext1 at level 1
        ext_flag[0] = 1;                   // edge-mode ext0 at level 0
        step(3);
        check(irq_o == 0, "R6 equal and lower levels held", int'(irq_o), 0);
        check(tmr_clr_o == 0, "R9 strobe lasts one cycle", int'(tmr_clr_o), 0);

        prio_hi[3] = 1; prio_lo[3] = 1; tmr_flag[1] = 1;
        step(1); expect_vec("R7 level 3 preempts level 1", 8'h1B);
        ack = 1; step(1);
        check(tmr_clr_o == 2'b10, "R9 timer1 clear strobe", int'(tmr_clr_o), 2);
        ack = 0; tmr_flag[1] = 0;
        step(2);
        pulse_reti(); step(2);
        check(irq_o == 0, "R11 return retires only level 3", int'(irq_o), 0);
        pulse_reti(); step(2);
        expect_vec("R7 held level 1 request after return", 8'h13);
        ack = 1; step(1);
        check(ext_clr_o == 2'b00, "R9 level-mode ext1 no strobe", int'(ext_clr_o), 0);
        ack = 0; ext_flag[1] = 0;
        step(2);
        check(irq_o == 0, "R6 level 0 held behind level 1", int'(irq_o), 0);
        pulse_reti(); step(2);
        expect_vec("R7 level 0 after return", 8'h03);
        ack = 1; step(1);
        check(ext_clr_o == 2'b01, "R9 edge-mode ext0 strobe", int'(ext_clr_o), 1);
        ack = 0; ext_flag[0] = 0;
        pulse_reti(); step(2);
        pulse_reti(); step(2);            // R11: return with empty stack

        ser_rx = 1;
        step(1); expect_vec("R11 empty return harmless, serial served", 8'h23);
        ack = 1; step(1);
        check(ext_clr_o == 0 && tmr_clr_o == 0, "R9 serial gets no strobe", int'({ext_clr_o, tmr_clr_o}), 0);
        ack = 0; ser_rx = 0;
        pulse_reti(); step(2);

        // R8: acknowledge with no request is ignored
        ack = 1; step(1); ack = 0;
        t2_ovf = 1;
        step(1); expect_vec("R8 stray ack left no level in service", 8'h2B);
        t2_ovf = 0; step(2);

        finish_run();
    end

endmodule